// File: doc/BRIEF.md
# Synthesizer Programming Word Loader

This block sits in front of a direct digital synthesizer core and collects the 40-bit word that programs it: a 32-bit frequency tuning word, a 5-bit phase offset, a power-down bit and a 2-bit control field. A host writes the word through an 8-bit port, one byte per rising edge of a slow load clock, or as a single-bit stream on bit 7 of that port. The word stays in a holding register until an update strobe commits it to the working register that drives the core. The commit raises a one-cycle pulse that tells the core a new word has been applied.

The load clock, update strobe, master reset and data pins are asynchronous to the system clock. Each goes through a two-stage synchronizer, and edge detectors turn the load clock and the update strobe into single-cycle events. A state machine tracks the loading position. ST_BYTE0 through ST_BYTE4 each take one byte and step to the next state. ST_BYTE4 steps to ST_FULL, where further loads are discarded. ST_SERIAL shifts one bit per load. An update in any parallel state returns to ST_BYTE0. The exception is an update that carries control code 11, which moves to ST_SERIAL. An update in ST_SERIAL stays in ST_SERIAL. Master reset forces ST_BYTE0 from every state.

Top module: `dds_word_loader`

## Requirements
- R1: In parallel mode, the five bytes map as follows. Byte 0 gives phase[4:0] from data bits 7..3, power-down from data bit 2 and control[1:0] from data bits 1..0. Bytes 1, 2, 3 and 4 give tuning-word bits 31:24, 23:16, 15:8 and 7:0, in that order.
- R2: After five parallel loads, further load-clock edges leave the holding register unchanged until an update or a master reset.
- R3: An update in parallel mode returns the byte position to byte 0, whether or not all five bytes were loaded.
- R4: An update with control code 00 copies the whole holding register to the outputs. The outputs change on the third system-clock rising edge after the strobe is first sampled high, together with a word_applied pulse exactly one cycle long. Outside a commit or a master reset the outputs do not change.
- R5: An update in parallel mode with control code 11 switches the block to serial mode. It does not commit, does not pulse word_applied and does not set the error flag.
- R6: In serial mode, each load edge shifts in data bit 7. The first bit becomes tuning-word bit 0 and the 32nd becomes bit 31. Bits 33 and 34 become control[0] and control[1], bit 35 becomes power-down, and bits 36 to 40 become phase[0] to phase[4]. The block remains in serial mode after an update.
- R7: While master reset is high, the block clears the working tuning word, phase, power-down and control, clears the error flag, returns the byte position to byte 0 and selects parallel mode. The holding register is left unchanged.
- R8: An update whose control code is reserved sets ctl_error, leaves the outputs unchanged and gives no word_applied pulse. In parallel mode the reserved codes are 01 and 10; in serial mode they are 01, 10 and 11. The flag then stays set until a master reset or a system reset.
- R9: When a load event and an update event fall in the same cycle, the byte is stored first and the update then commits a word that includes it.
- R10: A system reset clears every output and the holding register, and selects parallel mode at byte 0.
- R11: Load and update events that arrive while master reset is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| data_in | input | 8 | Parallel byte; bit 7 also carries the serial stream |
| load_clk | input | 1 | Asynchronous load clock, acts on its rising edge |
| update_stb | input | 1 | Asynchronous update strobe, acts on its rising edge |
| master_rst | input | 1 | Asynchronous active-high master reset (level) |
| tune_word | output | 32 | Working frequency tuning word |
| phase_word | output | 5 | Working phase offset |
| power_down | output | 1 | Working power-down bit |
| ctl_field | output | 2 | Working control field |
| word_applied | output | 1 | One-cycle pulse on each commit |
| ctl_error | output | 1 | Sticky reserved-code flag |

## Verification
The bench loads six bytes and then commits. A design whose pointer wraps instead of locking would overwrite byte 0 with the sixth byte. It commits after a partial load and then loads again. A design that does not rewind the pointer on update would land the new bytes in the middle of the tuning word. It fires a load and an update in the same cycle, which exposes a design that commits the previous contents. It sends serial words with known bit patterns, including a reserved control code, so a swapped bit order, a misplaced field or a commit of a test code shows up in the tuning word or the phase. Around master reset it pulses the load clock while reset is high and loads without an intermediate update after release. A design that clears the holding register, stays in serial mode or keeps the stale pointer would corrupt the tuning word that follows.

// File: rtl/dwl_pkg.sv
package dwl_pkg;
    localparam int FTW_W  = 32;
    localparam int PH_W   = 5;
    localparam int CTL_W  = 2;
    localparam int BYTE_W = 8;
    localparam int WORD_W = PH_W + 1 + CTL_W + FTW_W;
    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int IDX_W  = $clog2(NBYTES + 2);

    localparam logic [CTL_W-1:0] CTL_NORMAL = 2'b00;
    localparam logic [CTL_W-1:0] CTL_SERIAL = 2'b11;

    // Packed order equals the serial bit positions; byte 0 is the top byte.
    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic             pdown;
        logic [CTL_W-1:0] ctl;
        logic [FTW_W-1:0] ftw;
    } word_t;

    // Parallel states are encoded with their byte index.
    typedef enum logic [IDX_W-1:0] {
        ST_BYTE0  = 3'd0,
        ST_BYTE1  = 3'd1,
        ST_BYTE2  = 3'd2,
        ST_BYTE3  = 3'd3,
        ST_BYTE4  = 3'd4,
        ST_FULL   = 3'd5,
        ST_SERIAL = 3'd6
    } ld_state_t;
endpackage

// File: rtl/dwl_sync.sv
module dwl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dwl_seq.sv
module dwl_seq
    import dwl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mres,
    input  logic             load,
    input  logic             upd,
    input  logic [CTL_W-1:0] nxt_ctl,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             shift_en,
    output logic             commit,
    output logic             fault
);
    ld_state_t state_q, state_d, after_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BYTE0;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: load step first, update decision on top of it.
    always_comb begin
        after_load = state_q;
        if (load) begin
            unique case (state_q)
                ST_BYTE0:  after_load = ST_BYTE1;
                ST_BYTE1:  after_load = ST_BYTE2;
                ST_BYTE2:  after_load = ST_BYTE3;
                ST_BYTE3:  after_load = ST_BYTE4;
                ST_BYTE4:  after_load = ST_FULL;
                ST_FULL:   after_load = ST_FULL;
                ST_SERIAL: after_load = ST_SERIAL;
                default:   after_load = ST_BYTE0;
            endcase
        end
        state_d = after_load;
        if (upd) begin
            if (state_q == ST_SERIAL || nxt_ctl == CTL_SERIAL) begin
                state_d = ST_SERIAL;
            end else begin
                state_d = ST_BYTE0;
            end
        end
        if (mres) begin
            state_d = ST_BYTE0;
        end
    end

    // Outputs per state.
    always_comb begin
        wr_en    = 1'b0;
        wr_idx   = state_q;
        shift_en = 1'b0;
        commit   = 1'b0;
        fault    = 1'b0;
        if (!mres) begin
            unique case (state_q)
                ST_BYTE0, ST_BYTE1, ST_BYTE2, ST_BYTE3, ST_BYTE4: begin
                    wr_en  = load;
                    commit = upd && (nxt_ctl == CTL_NORMAL);
                    fault  = upd && (nxt_ctl != CTL_NORMAL) && (nxt_ctl != CTL_SERIAL);
                end
                ST_FULL: begin
                    commit = upd && (nxt_ctl == CTL_NORMAL);
                    fault  = upd && (nxt_ctl != CTL_NORMAL) && (nxt_ctl != CTL_SERIAL);
                end
                ST_SERIAL: begin
                    shift_en = load;
                    commit   = upd && (nxt_ctl == CTL_NORMAL);
                    fault    = upd && (nxt_ctl != CTL_NORMAL);
                end
                default: begin
                    wr_en = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dwl_inreg.sv
module dwl_inreg
    import dwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              shift_en,
    input  logic [BYTE_W-1:0] din,
    output word_t             nxt
);
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] flat;
    logic [NBYTES-1:0] lane_hit;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign lane_hit[b] = wr_en && (wr_idx == IDX_W'(b));
    end

    always_comb begin
        flat = hold_q;
        if (shift_en) begin
            flat = {din[BYTE_W-1], hold_q[WORD_W-1:1]};
        end else begin
            for (int b = 0; b < NBYTES; b++) begin
                if (lane_hit[b]) begin
                    flat[(NBYTES-1-b)*BYTE_W +: BYTE_W] = din;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= flat;
        end
    end

    assign nxt = word_t'(flat);
endmodule

// File: rtl/dwl_commit.sv
module dwl_commit
    import dwl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mres,
    input  logic  commit,
    input  logic  fault,
    input  word_t nxt,
    output word_t work,
    output logic  applied,
    output logic  err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work    <= '0;
            applied <= 1'b0;
            err     <= 1'b0;
        end else if (mres) begin
            work    <= '0;
            applied <= 1'b0;
            err     <= 1'b0;
        end else begin
            applied <= commit;
            if (commit) begin
                work <= nxt;
            end
            if (fault) begin
                err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
    import dwl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              load_clk,
    input  logic              update_stb,
    input  logic              master_rst,
    output logic [FTW_W-1:0]  tune_word,
    output logic [PH_W-1:0]   phase_word,
    output logic              power_down,
    output logic [CTL_W-1:0]  ctl_field,
    output logic              word_applied,
    output logic              ctl_error
);
    localparam int RAW_W = BYTE_W + 3;

    logic [RAW_W-1:0]  raw_pins;
    logic [RAW_W-1:0]  sync_pins;
    logic [BYTE_W-1:0] data_s;
    logic              load_s, upd_s, load_q, upd_q;
    logic              mres_lvl, load_evt, upd_evt;
    logic              wr_en, shift_en, commit, fault;
    logic [IDX_W-1:0]  wr_idx;
    word_t             nxt_word, work;

    assign raw_pins = {master_rst, update_stb, load_clk, data_in};

    dwl_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_pins),
        .q     (sync_pins)
    );

    assign data_s   = sync_pins[BYTE_W-1:0];
    assign load_s   = sync_pins[BYTE_W];
    assign upd_s    = sync_pins[BYTE_W+1];
    assign mres_lvl = sync_pins[BYTE_W+2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= 1'b0;
            upd_q  <= 1'b0;
        end else begin
            load_q <= load_s;
            upd_q  <= upd_s;
        end
    end

    assign load_evt = load_s & ~load_q;
    assign upd_evt  = upd_s & ~upd_q;

    dwl_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mres     (mres_lvl),
        .load     (load_evt),
        .upd      (upd_evt),
        .nxt_ctl  (nxt_word.ctl),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .shift_en (shift_en),
        .commit   (commit),
        .fault    (fault)
    );

    dwl_inreg u_inreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .shift_en (shift_en),
        .din      (data_s),
        .nxt      (nxt_word)
    );

    dwl_commit u_commit (
        .clk     (clk),
        .rst_n   (rst_n),
        .mres    (mres_lvl),
        .commit  (commit),
        .fault   (fault),
        .nxt     (nxt_word),
        .work    (work),
        .applied (word_applied),
        .err     (ctl_error)
    );

    assign tune_word  = work.ftw;
    assign phase_word = work.phase;
    assign power_down = work.pdown;
    assign ctl_field  = work.ctl;
endmodule

// File: rtl/dds_word_loader_chk.sv
module dds_word_loader_chk
    import dwl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mres_lvl,
    input logic [FTW_W-1:0] tune_word,
    input logic [PH_W-1:0]  phase_word,
    input logic             power_down,
    input logic [CTL_W-1:0] ctl_field,
    input logic             word_applied,
    input logic             ctl_error
);
    // R4: the applied pulse never lasts two cycles
    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_applied |=> !word_applied);

    // R4: outputs move only on a commit or a master reset
    assert_hold_between_commits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({tune_word, phase_word, power_down, ctl_field}) |-> (word_applied || $past(mres_lvl)));

    // R7: master reset clears the working fields and the flag
    assert_mreset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mres_lvl) |-> (tune_word == '0 && phase_word == '0 && !power_down && !ctl_error && !word_applied));

    // R8: flag stays set until a master reset
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_error && !mres_lvl) |=> ctl_error);

    // R8: a reserved code never commits
    assert_err_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_error) |-> !word_applied);

    // R8: a committed word always carries the normal control code
    assert_clean_ctl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_applied |-> (ctl_field == CTL_NORMAL));
endmodule

bind dds_word_loader dds_word_loader_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mres_lvl     (mres_lvl),
    .tune_word    (tune_word),
    .phase_word   (phase_word),
    .power_down   (power_down),
    .ctl_field    (ctl_field),
    .word_applied (word_applied),
    .ctl_error    (ctl_error)
);

// File: tb/dds_word_loader_tb.sv
module dds_word_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  data_in = 8'h00;
    logic        load_clk = 1'b0;
    logic        update_stb = 1'b0;
    logic        master_rst = 1'b0;
    logic [31:0] tune_word;
    logic [4:0]  phase_word;
    logic        power_down;
    logic [1:0]  ctl_field;
    logic        word_applied;
    logic        ctl_error;

    int    checks = 0;
    int    errors = 0;
    int    app_cnt = 0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R10";

    always #4 clk = ~clk;

    dds_word_loader u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_in      (data_in),
        .load_clk     (load_clk),
        .update_stb   (update_stb),
        .master_rst   (master_rst),
        .tune_word    (tune_word),
        .phase_word   (phase_word),
        .power_down   (power_down),
        .ctl_field    (ctl_field),
        .word_applied (word_applied),
        .ctl_error    (ctl_error)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: pins seen two edges late, edges against three.
    typedef struct packed {
        logic       w;
        logic       u;
        logic       m;
        logic [7:0] d;
    } pins_t;

    pins_t       hist[$];
    logic [39:0] m_in, m_work;
    int          m_ptr;
    bit          m_ser, m_err, m_app;

    always @(posedge clk) begin : model
        pins_t a;
        pins_t b;
        logic [1:0] code;
        if (!rst_n) begin
            m_in = '0; m_work = '0; m_ptr = 0;
            m_ser = 0; m_err = 0; m_app = 0;
            hist.delete();
            repeat (3) hist.push_front('0);
        end else begin
            a = hist[1];
            b = hist[2];
            m_app = 0;
            if (a.m) begin
                m_work = '0; m_ptr = 0; m_ser = 0; m_err = 0;
            end else begin
                if (a.w && !b.w) begin
                    if (m_ser) m_in = {a.d[7], m_in[39:1]};
                    else if (m_ptr < 5) begin
                        m_in[(4 - m_ptr) * 8 +: 8] = a.d;
                        m_ptr++;
                    end
                end
                if (a.u && !b.u) begin
                    code = m_in[33:32];
                    if (code == 2'b00) begin
                        m_work = m_in;
                        m_app = 1;
                    end else if (code == 2'b11 && !m_ser) begin
                        m_ser = 1;
                    end else begin
                        m_err = 1;
                    end
                    m_ptr = 0;
                end
            end
            hist.push_front(pins_t'{w: load_clk, u: update_stb, m: master_rst, d: data_in});
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (rst_n && started && !done) begin
            chk({cur_req, " model tune"}, tune_word, m_work[31:0]);
            chk({cur_req, " model phase"}, phase_word, m_work[39:35]);
            chk({cur_req, " model pdown"}, power_down, m_work[34]);
            chk({cur_req, " model ctl"}, ctl_field, m_work[33:32]);
            chk({cur_req, " model applied"}, word_applied, m_app);
            chk({cur_req, " model err"}, ctl_error, m_err);
            if (word_applied) app_cnt++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] d);
        data_in = d;
        idle(1);
        load_clk = 1'b1;
        idle(4);
        load_clk = 1'b0;
        idle(4);
    endtask

    task automatic strobe();
        update_stb = 1'b1;
        idle(4);
        update_stb = 1'b0;
        idle(4);
    endtask

    task automatic put_serial(input logic [39:0] w);
        for (int i = 0; i < 40; i++) put_byte({w[i], 7'h00});
    endtask

    task automatic mreset_pulse();
        master_rst = 1'b1;
        idle(6);
        master_rst = 1'b0;
        idle(4);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R4 watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int base;
        idle(5);
        rst_n = 1'b1;
        idle(2);
        started = 1'b1;

        // R10: reset state
        chk("R10 tune", tune_word, 0);
        chk("R10 phase", phase_word, 0);
        chk("R10 err", ctl_error, 0);
        chk("R10 applied", word_applied, 0);

        // R1 byte mapping, R4 latency and hold
        cur_req = "R1";
        put_byte(8'hA8); put_byte(8'h12); put_byte(8'h34); put_byte(8'h56); put_byte(8'h78);
        chk("R4 no change before update", tune_word, 0);
        base = app_cnt;
        cur_req = "R4";
        update_stb = 1'b1;
        idle(2);
        chk("R4 still old after two edges", tune_word, 0);
        idle(1);
        chk("R4 new word on third edge", tune_word, 32'h12345678);
        chk("R4 pulse high", word_applied, 1);
        idle(1);
        chk("R4 pulse low", word_applied, 0);
        update_stb = 1'b0;
        idle(4);
        chk("R1 phase from byte 0", phase_word, 5'h15);
        chk("R1 pdown from byte 0", power_down, 0);
        chk("R4 one pulse", app_cnt - base, 1);

        // R2: sixth byte ignored
        cur_req = "R2";
        put_byte(8'h04); put_byte(8'hDE); put_byte(8'hAD); put_byte(8'hBE); put_byte(8'hEF);
        put_byte(8'h11);
        strobe();
        chk("R2 tune", tune_word, 32'hDEADBEEF);
        chk("R2 pdown", power_down, 1);
        chk("R2 phase", phase_word, 0);

        // R3: partial load, update rewinds pointer
        cur_req = "R3";
        put_byte(8'h08); put_byte(8'h99);
        strobe();
        chk("R3 partial tune", tune_word, 32'h99ADBEEF);
        chk("R3 partial phase", phase_word, 1);
        put_byte(8'h10); put_byte(8'h55);
        strobe();
        chk("R3 rewound tune", tune_word, 32'h55ADBEEF);
        chk("R3 rewound phase", phase_word, 2);

        // R9: load and update together
        cur_req = "R9";
        data_in = 8'h18;
        idle(1);
        load_clk = 1'b1;
        update_stb = 1'b1;
        idle(4);
        load_clk = 1'b0;
        update_stb = 1'b0;
        idle(4);
        chk("R9 phase includes same-cycle byte", phase_word, 3);
        chk("R9 tune", tune_word, 32'h55ADBEEF);

        // R8: reserved parallel code
        cur_req = "R8";
        base = app_cnt;
        put_byte(8'h01);
        strobe();
        chk("R8 err set", ctl_error, 1);
        chk("R8 phase kept", phase_word, 3);
        chk("R8 no pulse", app_cnt - base, 0);
        put_byte(8'h24);
        strobe();
        chk("R8 err sticky", ctl_error, 1);
        chk("R8 later commit phase", phase_word, 4);
        chk("R8 later commit pdown", power_down, 1);

        // R7 and R11: master reset
        cur_req = "R7";
        put_byte(8'h20);
        master_rst = 1'b1;
        idle(3);
        cur_req = "R11";
        base = app_cnt;
        put_byte(8'hFF);
        strobe();
        master_rst = 1'b0;
        idle(4);
        chk("R7 tune cleared", tune_word, 0);
        chk("R7 pdown cleared", power_down, 0);
        chk("R7 err cleared", ctl_error, 0);
        chk("R11 no pulse in reset", app_cnt - base, 0);
        cur_req = "R7";
        put_byte(8'h28);
        strobe();
        chk("R11 byte ignored in reset", tune_word, 32'h55ADBEEF);
        chk("R7 pointer at byte 0", phase_word, 5);

        // R5: serial entry
        cur_req = "R5";
        base = app_cnt;
        put_byte(8'h03);
        strobe();
        chk("R5 no pulse", app_cnt - base, 0);
        chk("R5 no err", ctl_error, 0);
        chk("R5 phase kept", phase_word, 5);

        // R6: serial order
        cur_req = "R6";
        put_serial({5'h13, 1'b1, 2'b00, 32'h0F1E2D3C});
        chk("R6 no change before update", tune_word, 32'h55ADBEEF);
        strobe();
        chk("R6 tune", tune_word, 32'h0F1E2D3C);
        chk("R6 phase", phase_word, 5'h13);
        chk("R6 pdown", power_down, 1);
        put_serial({5'h07, 1'b0, 2'b00, 32'hCAFE0001});
        strobe();
        chk("R6 stays serial tune", tune_word, 32'hCAFE0001);
        chk("R6 stays serial phase", phase_word, 5'h07);

        // R8: reserved serial code
        cur_req = "R8";
        put_serial({5'h1F, 1'b0, 2'b01, 32'h11111111});
        strobe();
        chk("R8 serial err", ctl_error, 1);
        chk("R8 serial tune kept", tune_word, 32'hCAFE0001);

        // R7: back to parallel
        cur_req = "R7";
        mreset_pulse();
        put_byte(8'h00); put_byte(8'h01); put_byte(8'h02); put_byte(8'h03); put_byte(8'h04);
        strobe();
        chk("R7 parallel after reset", tune_word, 32'h01020304);
        chk("R7 err clear", ctl_error, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule